// File: doc/BRIEF.md
# Selectable-Policy Data Cache

This block is a level-one data cache that sits between a processor load/store port and a block-wide main memory. It is two-way set associative with eight sets. Each line holds eight words, and all addressing is in words. A hit completes in the cycle of the request. A miss holds the processor stalled while the controller talks to memory. Memory has a fixed latency and moves a whole line in a single beat.

A static input `wb_mode` picks one of two write policies. In write-through mode (`wb_mode` = 0), every store goes to memory as a single masked word, and a store miss leaves the cache unchanged. In write-back mode (`wb_mode` = 1), a store hit stays in the cache and marks the line dirty. A store miss first fetches the line and then writes it. Replacing a dirty line writes that line back to memory before the refill read. The victim is never the way used most recently in its set.

The processor holds `cpu_req` and its fields stable until `cpu_ready` is high. The cycle in which `cpu_ready` is high completes the access. The memory side is a level handshake: `mem_req` stays high until `mem_done`.

Top module: `dcache_top`

## Requirements
- R1: While reset is applied, and after it with no request pending, `mem_req` and `cpu_ready` are low. Every line is invalid after reset, so the first access to any address misses.
- R2: A load that hits raises `cpu_ready` in the same cycle as the request. `cpu_rdata` carries the most recent value stored to that word address.
- R3: A load miss whose victim is clean issues exactly one memory read of block address `cpu_addr[ADDR_W-1:3]`. `cpu_ready` rises in the cycle after `mem_done`. With a memory that answers in the 20th request cycle, that is 21 cycles after the request cycle.
- R4: From the cycle `mem_req` rises until the cycle `mem_done` is high, `mem_req`, `mem_we` and `mem_addr` stay constant. Word i of a line travels in `mem_wdata`/`mem_rdata` bits [i*DATA_W +: DATA_W].
- R5: With `wb_mode` = 0, every store (hit or miss) issues one memory write. Its address is the word's block, and only mask bit `cpu_addr[2:0]` is set. `cpu_ready` rises in the same cycle as `mem_done` (20 cycles after the request). A store hit also updates the cached word. A store miss allocates nothing, so a later load of that address misses.
- R6: With `wb_mode` = 1, a store hit completes in the request cycle and causes no memory transfer. The new value is returned by later loads.
- R7: With `wb_mode` = 1, a store miss first refills the line and then performs the store in the cache. `cpu_ready` rises in the cycle after the refill's `mem_done`.
- R8: With `wb_mode` = 1, a miss whose victim is dirty first writes the whole victim line to the victim's own block address with all mask bits set. Only after that write's `mem_done` does it issue the refill read, which adds 20 cycles (41 in total).
- R9: The victim is chosen in this order: invalid way 0, then invalid way 1, then the way other than the one most recently touched by a hit or a refill in that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | Write policy: 0 write-through/no-allocate, 1 write-back/allocate; static |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W (10) | Word address |
| cpu_wdata | input | DATA_W (32) | Store data |
| cpu_rdata | output | DATA_W (32) | Load data, valid while `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory request, held until `mem_done` |
| mem_we | output | 1 | 1 for a memory write, 0 for a line read |
| mem_addr | output | ADDR_W-3 (7) | Block address |
| mem_wdata | output | WORDS*DATA_W (256) | Write line, word i in lane i |
| mem_wmask | output | WORDS (8) | Per-word write enable, bit i for word i |
| mem_rdata | input | WORDS*DATA_W (256) | Read line, sampled in the `mem_done` cycle |
| mem_done | input | 1 | Memory completes the pending request in this cycle |

## Verification
Two events share a cycle in two places. In write-through stores, the memory acknowledge and the processor release fall in the same cycle. In a dirty replacement, the end of the write-back and the start of the refill coincide, and both address the same set and way. Directed stores to cached and uncached words provoke the first. A conflict sequence that dirties one way, touches the other and then misses in that set provokes the second. Both are judged by the exact cycle of `cpu_ready`, the number and kind of memory transfers, and the contents of the bench memory afterwards (the evicted line must arrive intact before the refill overwrites the way). Seeded random traffic confined to a few sets and tags then mixes these cases with hits and clean misses in both modes.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
   localparam int unsigned NWAYS = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2,
      ST_WTHRU = 2'd3
   } dc_state_e;
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags
   import dcache_pkg::*;
#(
   parameter int unsigned SETS  = 8,
   parameter int unsigned TAG_W = 4,
   localparam int unsigned IDX_W = $clog2(SETS)
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             idx,
   input  logic [TAG_W-1:0]             tag,
   output logic                         hit,
   output logic                         hit_way,
   output logic                         vic_way,
   output logic [NWAYS-1:0][TAG_W-1:0]  way_tag,
   output logic [NWAYS-1:0]             way_dirty,
   input  logic                         touch_en,
   input  logic                         touch_way,
   input  logic                         fill_en,
   input  logic                         fill_way,
   input  logic                         dirty_en,
   input  logic                         dirty_way
);
   logic [NWAYS-1:0] way_valid;
   logic [NWAYS-1:0] match;
   logic [SETS-1:0]  mru_q;

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      logic [SETS-1:0]  valid_q;
      logic [SETS-1:0]  dirty_q;
      logic [TAG_W-1:0] tag_q [SETS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
         end else if (fill_en && fill_way == 1'(w)) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
         end else if (dirty_en && dirty_way == 1'(w)) begin
            dirty_q[idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_en && fill_way == 1'(w)) tag_q[idx] <= tag;
      end

      assign way_valid[w] = valid_q[idx];
      assign way_dirty[w] = dirty_q[idx];
      assign way_tag[w]   = tag_q[idx];
      assign match[w]     = valid_q[idx] && (tag_q[idx] == tag);
   end

   assign hit     = |match;
   assign hit_way = match[1];

   // invalid ways first, lowest way first; otherwise the not-last-used way
   always_comb begin
      if (!way_valid[0])      vic_way = 1'b0;
      else if (!way_valid[1]) vic_way = 1'b1;
      else                    vic_way = ~mru_q[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mru_q      <= '0;
      else if (touch_en) mru_q[idx] <= touch_way;
   end
endmodule

// File: rtl/dcache_data.sv
module dcache_data
   import dcache_pkg::*;
#(
   parameter int unsigned SETS   = 8,
   parameter int unsigned WORDS  = 8,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W  = $clog2(SETS),
   localparam int unsigned OFF_W  = $clog2(WORDS),
   localparam int unsigned LINE_W = WORDS * DATA_W
)(
   input  logic                          clk,
   input  logic [IDX_W-1:0]              idx,
   output logic [NWAYS-1:0][LINE_W-1:0]  rd_lines,
   input  logic                          wr_way,
   input  logic                          word_en,
   input  logic [OFF_W-1:0]              word_off,
   input  logic [DATA_W-1:0]             word_data,
   input  logic                          line_en,
   input  logic [LINE_W-1:0]             line_data
);
   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      logic [LINE_W-1:0] line_q [SETS];

      always_ff @(posedge clk) begin
         if (wr_way == 1'(w)) begin
            if (line_en)      line_q[idx] <= line_data;
            else if (word_en) line_q[idx][word_off*DATA_W +: DATA_W] <= word_data;
         end
      end

      assign rd_lines[w] = line_q[idx];
   end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
   import dcache_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wb_mode,
   input  logic      cpu_req,
   input  logic      cpu_we,
   input  logic      hit,
   input  logic      vic_way,
   input  logic      vic_dirty,
   input  logic      mem_done,
   output dc_state_e state,
   output logic      vic_q,
   output logic      cpu_ready,
   output logic      mem_req,
   output logic      mem_we,
   output logic      touch_en,
   output logic      fill_en,
   output logic      dirty_en,
   output logic      word_en
);
   dc_state_e state_q, state_d;

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      touch_en  = 1'b0;
      fill_en   = 1'b0;
      dirty_en  = 1'b0;
      word_en   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (cpu_we && !wb_mode) begin
                  state_d = ST_WTHRU;
                  if (hit) begin
                     word_en  = 1'b1;
                     touch_en = 1'b1;
                  end
               end else if (hit) begin
                  cpu_ready = 1'b1;
                  touch_en  = 1'b1;
                  if (cpu_we) begin
                     word_en  = 1'b1;
                     dirty_en = 1'b1;
                  end
               end else begin
                  state_d = (wb_mode && vic_dirty) ? ST_EVICT : ST_FILL;
               end
            end
         end
         ST_EVICT: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_done) state_d = ST_FILL;
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_done) begin
               fill_en = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_WTHRU: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_done) begin
               cpu_ready = 1'b1;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vic_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req && !hit) vic_q <= vic_way;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/dcache_top.sv
module dcache_top
   import dcache_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 8,
   parameter int unsigned SETS   = 8,
   localparam int unsigned OFF_W  = $clog2(WORDS),
   localparam int unsigned IDX_W  = $clog2(SETS),
   localparam int unsigned BLK_W  = ADDR_W - OFF_W,
   localparam int unsigned TAG_W  = BLK_W - IDX_W,
   localparam int unsigned LINE_W = WORDS * DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_mode,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [BLK_W-1:0]  mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   output logic [WORDS-1:0]  mem_wmask,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_done
);
   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_bad_words
      $error("dcache_top: WORDS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("dcache_top: SETS must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
      $error("dcache_top: ADDR_W leaves no tag bits");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dcache_top: DATA_W must be positive");
   end

   logic [OFF_W-1:0] off;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;

   assign off = cpu_addr[OFF_W-1:0];
   assign idx = cpu_addr[OFF_W +: IDX_W];
   assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

   logic                         hit, hit_way, vic_way, vic_q;
   logic [NWAYS-1:0][TAG_W-1:0]  way_tag;
   logic [NWAYS-1:0]             way_dirty;
   logic [NWAYS-1:0][LINE_W-1:0] rd_lines;
   logic                         touch_en, fill_en, dirty_en, word_en;
   logic                         data_way;
   dc_state_e                    state;

   dcache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .tag       (tag),
      .hit       (hit),
      .hit_way   (hit_way),
      .vic_way   (vic_way),
      .way_tag   (way_tag),
      .way_dirty (way_dirty),
      .touch_en  (touch_en),
      .touch_way (hit_way),
      .fill_en   (fill_en),
      .fill_way  (vic_q),
      .dirty_en  (dirty_en),
      .dirty_way (hit_way)
   );

   dcache_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wb_mode   (wb_mode),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .hit       (hit),
      .vic_way   (vic_way),
      .vic_dirty (way_dirty[vic_way]),
      .mem_done  (mem_done),
      .state     (state),
      .vic_q     (vic_q),
      .cpu_ready (cpu_ready),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .touch_en  (touch_en),
      .fill_en   (fill_en),
      .dirty_en  (dirty_en),
      .word_en   (word_en)
   );

   assign data_way = fill_en ? vic_q : hit_way;

   dcache_data #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk       (clk),
      .idx       (idx),
      .rd_lines  (rd_lines),
      .wr_way    (data_way),
      .word_en   (word_en),
      .word_off  (off),
      .word_data (cpu_wdata),
      .line_en   (fill_en),
      .line_data (mem_rdata)
   );

   assign cpu_rdata = rd_lines[hit_way][off*DATA_W +: DATA_W];

   always_comb begin
      mem_addr  = {tag, idx};
      mem_wdata = {WORDS{cpu_wdata}};
      mem_wmask = '0;
      if (state == ST_EVICT) begin
         mem_addr  = {way_tag[vic_q], idx};
         mem_wdata = rd_lines[vic_q];
         mem_wmask = '1;
      end else if (state == ST_WTHRU) begin
         mem_wmask = WORDS'(1) << off;
      end
   end
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
   parameter int unsigned WORDS = 8,
   parameter int unsigned BLK_W = 7
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wb_mode,
   input logic             cpu_req,
   input logic             cpu_ready,
   input logic             mem_req,
   input logic             mem_we,
   input logic [BLK_W-1:0] mem_addr,
   input logic [WORDS-1:0] mem_wmask,
   input logic             mem_done
);
   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_done |=> mem_req);

   // R4
   mem_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_done |=> $stable(mem_addr) && $stable(mem_we));

   // R5
   wt_one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && !wb_mode |-> $countones(mem_wmask) == 1);

   // R8
   wb_full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && wb_mode |-> &mem_wmask);

   // R8
   evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_done && wb_mode |=> mem_req && !mem_we);

   // R3
   fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_done && !mem_we && cpu_req |=> cpu_ready);

   // R2
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);
endmodule

bind dcache_top dcache_chk #(.WORDS(WORDS), .BLK_W(BLK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wb_mode   (wb_mode),
   .cpu_req   (cpu_req),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wmask (mem_wmask),
   .mem_done  (mem_done)
);

// File: tb/sim_dcache_top.sv
module sim_dcache_top;
   localparam int AW  = 10;
   localparam int DW  = 32;
   localparam int NW  = 8;
   localparam int NS  = 8;
   localparam int LAT = 20;
   localparam int BW  = AW - 3;
   localparam int LW  = NW * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wb_mode = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_ready;
   logic          mem_req, mem_we, mem_done;
   logic [BW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata, mem_rdata;
   logic [NW-1:0] mem_wmask;

   always #2 clk = ~clk;

   dcache_top u0 (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wmask(mem_wmask), .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   // memory model: answers in the LAT-th cycle of a held request
   logic [DW-1:0] mem  [1 << AW];
   logic [DW-1:0] refm [1 << AW];
   int            cnt = 0;
   int            rd_n = 0, wr_n = 0;
   logic [NW-1:0] last_mask = '0;
   logic [BW-1:0] last_addr = '0;

   assign mem_done = mem_req && (cnt == LAT - 1);

   always_comb begin
      for (int i = 0; i < NW; i++) mem_rdata[i*DW +: DW] = mem[{mem_addr, 3'(i)}];
   end

   always @(posedge clk) begin
      if (!mem_req || cnt == LAT - 1) cnt <= 0;
      else cnt <= cnt + 1;
      if (mem_req && mem_done) begin
         if (mem_we) begin
            for (int i = 0; i < NW; i++)
               if (mem_wmask[i]) mem[{mem_addr, 3'(i)}] <= mem_wdata[i*DW +: DW];
            wr_n      <= wr_n + 1;
            last_mask <= mem_wmask;
            last_addr <= mem_addr;
         end else begin
            rd_n <= rd_n + 1;
         end
      end
   end

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // reference model of tag state, built from the requirements
   bit       bv [NS][2];
   bit       bd [NS][2];
   bit [3:0] bt [NS][2];
   int       bm [NS];

   task automatic model_reset();
      for (int s = 0; s < NS; s++) begin
         bm[s] = 0;
         for (int w = 0; w < 2; w++) begin
            bv[s][w] = 0; bd[s][w] = 0; bt[s][w] = '0;
         end
      end
   endtask

   function automatic logic [AW-1:0] mk(input int t, input int s, input int o);
      return {4'(t), 3'(s), 3'(o)};
   endfunction

   task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input string force_rq);
      int idx, hw, v, exp_lat, exp_rd, exp_wr, lat, rd0, wr0;
      bit evict;
      logic [3:0]    tg;
      logic [BW-1:0] vblk;
      logic [DW-1:0] rv;
      string rq;
      idx = int'(a[5:3]); tg = a[9:6]; hw = -1;
      exp_lat = 0; exp_rd = 0; exp_wr = 0; evict = 0; vblk = '0;
      for (int w = 0; w < 2; w++) if (bv[idx][w] && bt[idx][w] == tg) hw = w;
      if (we && !wb_mode) begin
         exp_lat = 20; exp_wr = 1; rq = "R5";
         if (hw >= 0) bm[idx] = hw;
      end else if (hw >= 0) begin
         rq = we ? "R6" : "R2";
         if (we) bd[idx][hw] = 1;
         bm[idx] = hw;
      end else begin
         v = !bv[idx][0] ? 0 : (!bv[idx][1] ? 1 : 1 - bm[idx]);
         if (wb_mode && bv[idx][v] && bd[idx][v]) begin
            exp_lat = 41; exp_wr = 1; exp_rd = 1; rq = "R8"; evict = 1;
            vblk = {bt[idx][v], 3'(idx)};
         end else begin
            exp_lat = 21; exp_rd = 1; rq = we ? "R7" : "R3";
         end
         bv[idx][v] = 1; bt[idx][v] = tg; bd[idx][v] = we; bm[idx] = v;
      end
      if (force_rq != "") rq = force_rq;

      rd0 = rd_n; wr0 = wr_n;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      lat = 0;
      #1;
      while (!cpu_ready && lat < 200) begin
         @(negedge clk); #1; lat++;
      end
      rv = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;

      chk(lat == exp_lat, rq, "ready cycle", lat, exp_lat);
      chk(rd_n - rd0 == exp_rd, rq, "memory reads", rd_n - rd0, exp_rd);
      chk(wr_n - wr0 == exp_wr, rq, "memory writes", wr_n - wr0, exp_wr);
      if (!we) begin
         chk(rv == refm[a], rq, "load data", rv, refm[a]);
      end else begin
         refm[a] = d;
         if (!wb_mode) begin
            chk(mem[a] == d, rq, "memory word", mem[a], d);
            chk(last_mask == (NW'(1) << a[2:0]), rq, "write mask", last_mask, NW'(1) << a[2:0]);
            chk(last_addr == a[AW-1:3], rq, "write block", last_addr, a[AW-1:3]);
         end
      end
      if (evict) begin
         bit same = 1;
         for (int i = 0; i < NW; i++) if (mem[{vblk, 3'(i)}] !== refm[{vblk, 3'(i)}]) same = 0;
         chk(same, "R8", "evicted line intact", same, 1);
      end
   endtask

   task automatic random_run(input int n);
      for (int k = 0; k < n; k++) begin
         bit we = ($urandom_range(0, 2) == 0);
         access(we, mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7)),
                $urandom, "");
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL R4 watchdog actual=hung expected=complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      for (int i = 0; i < (1 << AW); i++) begin
         mem[i]  = 32'(i) * 32'h9E37_79B9 ^ 32'h0F0F_5A5A;
         refm[i] = mem[i];
      end
      model_reset();
      repeat (3) @(negedge clk);
      #1;
      chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "outputs in reset", {cpu_ready, mem_req}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", {cpu_ready, mem_req}, 0);

      // write-through phase
      access(0, mk(1, 0, 2), '0, "R1");
      access(0, mk(1, 0, 2), '0, "");
      access(0, mk(1, 0, 5), '0, "");
      access(1, mk(1, 0, 5), 32'hCAFE_0001, "");
      access(0, mk(1, 0, 5), '0, "R5");
      access(1, mk(2, 1, 3), 32'h1234_5678, "");
      access(0, mk(2, 1, 3), '0, "R5");
      access(0, mk(1, 2, 0), '0, "");
      access(0, mk(2, 2, 0), '0, "R9");
      access(0, mk(1, 2, 1), '0, "");
      access(0, mk(3, 2, 0), '0, "R9");
      access(0, mk(1, 2, 7), '0, "R9");
      access(0, mk(2, 2, 7), '0, "R9");
      random_run(150);

      // write-back phase
      @(negedge clk); rst_n = 1'b0; wb_mode = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "outputs in second reset", {cpu_ready, mem_req}, 0);
      rst_n = 1'b1;
      model_reset();
      access(1, mk(1, 0, 0), 32'h0000_D00D, "");
      access(0, mk(1, 0, 0), '0, "R7");
      access(1, mk(1, 0, 4), 32'h0000_BEEF, "");
      access(0, mk(1, 0, 4), '0, "R6");
      access(0, mk(2, 0, 0), '0, "");
      access(0, mk(3, 0, 0), '0, "");
      access(0, mk(1, 0, 4), '0, "R8");
      random_run(150);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule